// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block sits next to a simple in-order CPU core and performs the entry half of exception handling. The core raises synchronous exception requests with a cause code, and external devices and the tick timer raise interrupt-pending lines. The block decides which event is taken, writes the pre-trap status into a shadow copy, forces the live status register into a safe supervisor state, and records the resume address and the faulting effective address. It then gives the core a one-cycle redirect with the handler address.

The handler address is built from the cause code placed at bit 8, with a vector base value merged in when the configuration says a base register exists, and with the top nibble forced high when the status register asks for high vectors. A synchronous request is first held in a pending register and is entered on the following clock edge. Interrupts are arbitrated directly from the live pending lines, gated by their enable bits. Requests with an unsupported code are dropped and flagged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status register reads 0x0001 (supervisor only), the saved status, return PC and effective-address registers read 0, redirect_valid is 0 and bad_code_err is 0.
- R2: A synchronous request with a code from 1 to 12 (1 reset, 2 bus error, 3 data protection, 4 instruction protection, 5 tick, 6 alignment, 7 illegal, 8 external interrupt, 9 data TLB miss, 10 instruction TLB miss, 11 range, 12 system call) sampled at one rising edge is entered at the next edge, giving exactly one redirect_valid pulse one cycle wide.
- R3: redirect_pc equals (code << 8), ORed with vbar_base when cfg_vbar_present is 1, ORed with 0xF0000000 when status bit 5 (high vectors) was set before entry.
- R4: On entry the saved status register receives the status register value from before the entry.
- R5: On entry the status register sets bit 0 (supervisor), clears bit 1 (tick enable), bit 2 (interrupt enable), bit 3 (data MMU enable) and bit 4 (instruction MMU enable), keeps every other bit, and sets bit 6 to the delay-slot flag of the trapping instruction.
- R6: The return PC register receives the PC of the trapping instruction, except for code 12, where it receives that PC plus 4.
- R7: The effective-address register receives the instruction PC for code 7, the faulting address for other synchronous codes, and is left unchanged by interrupts.
- R8: An external interrupt (code 8) is taken only when status bit 2 is set and a timer interrupt (code 5) only when status bit 1 is set; when both are pending and enabled the timer is taken.
- R9: A pending synchronous request is taken ahead of any interrupt pending in the same cycle.
- R10: A request with code 0 or above 12 produces no entry and sets bad_code_err, which then stays set until reset.
- R11: When sr_wr_en is 1 and no entry occurs, the status register loads sr_wr_data; during an entry the write is dropped; otherwise the status register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_valid | input | 1 | Synchronous exception request strobe |
| exc_req_code | input | 4 | Cause code of the request |
| core_pc | input | 32 | PC of the current instruction |
| core_in_dslot | input | 1 | Current instruction sits in a delay slot |
| core_fault_addr | input | 32 | Faulting effective address |
| irq_ext_pending | input | 1 | External interrupt pending |
| irq_tick_pending | input | 1 | Timer interrupt pending |
| cfg_vbar_present | input | 1 | Vector base register is implemented |
| vbar_base | input | 32 | Vector base value |
| sr_wr_en | input | 1 | Core write strobe for the status register |
| sr_wr_data | input | 16 | Core write data for the status register |
| sr_q | output | 16 | Status register |
| esr_q | output | 16 | Saved status register |
| epc_q | output | 32 | Return PC |
| eear_q | output | 32 | Effective-address register |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Handler address |
| bad_code_err | output | 1 | Sticky unsupported-code flag |

## Verification
Every cycle the assertions check that an entry leaves the status register in supervisor state with both interrupt enables and both MMU enables cleared, that the saved status equals the previous status, that a plain vector has only bits 11:8 set, that the error flag is sticky and that the status register never moves without a write or an entry. Which event wins arbitration, the syscall return address, the illegal-instruction effective address, the delay-slot flag and the single pulse per request depend on the stimulus history, so only the bench's scenarios and its per-cycle reference model show them.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // cause codes, priority among interrupts is handled in the arbiter
  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_RESET   = 4'd1,
    EXC_BUSERR  = 4'd2,
    EXC_DPROT   = 4'd3,
    EXC_IPROT   = 4'd4,
    EXC_TICK    = 4'd5,
    EXC_ALIGN   = 4'd6,
    EXC_ILLEGAL = 4'd7,
    EXC_EXTINT  = 4'd8,
    EXC_DTMISS  = 4'd9,
    EXC_ITMISS  = 4'd10,
    EXC_RANGE   = 4'd11,
    EXC_SYSCALL = 4'd12
  } exc_code_e;

  // status register bit positions
  localparam int SR_SUP  = 0;
  localparam int SR_TEN  = 1;
  localparam int SR_IEN  = 2;
  localparam int SR_DMMU = 3;
  localparam int SR_IMMU = 4;
  localparam int SR_HIV  = 5;
  localparam int SR_DSX  = 6;

  localparam int VEC_SHIFT  = 8;
  localparam int INSN_BYTES = 4;

endpackage

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int AW = 32,
  parameter int NUM_CAUSES = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_code,
  input  logic [AW-1:0] req_pc,
  input  logic          req_dslot,
  input  logic [AW-1:0] req_addr,
  input  logic          consume,
  output logic          pend_valid,
  output logic [CW-1:0] pend_code,
  output logic [AW-1:0] pend_pc,
  output logic          pend_dslot,
  output logic [AW-1:0] pend_addr,
  output logic          code_err
);

  logic in_range, load_en, valid_d, err_d;

  assign in_range = (req_code != '0) && (int'(req_code) <= NUM_CAUSES);
  assign load_en  = req_valid && in_range;

  always_comb begin
    valid_d = pend_valid;
    if (consume) valid_d = 1'b0;
    if (load_en) valid_d = 1'b1;
    err_d = code_err | (req_valid & ~in_range);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      code_err   <= 1'b0;
    end else begin
      pend_valid <= valid_d;
      code_err   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code  <= '0;
      pend_pc    <= '0;
      pend_dslot <= 1'b0;
      pend_addr  <= '0;
    end else if (load_en) begin
      pend_code  <= req_code;
      pend_pc    <= req_pc;
      pend_dslot <= req_dslot;
      pend_addr  <= req_addr;
    end
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          pend_valid,
  input  logic [CW-1:0] pend_code,
  input  logic [AW-1:0] pend_pc,
  input  logic          pend_dslot,
  input  logic [AW-1:0] pend_addr,
  input  logic          irq_ext,
  input  logic          irq_tick,
  input  logic          ext_en,
  input  logic          tick_en,
  input  logic [AW-1:0] core_pc,
  input  logic          core_dslot,
  output logic          take,
  output logic          take_sync,
  output logic [CW-1:0] sel_code,
  output logic [AW-1:0] sel_epc,
  output logic          sel_dslot,
  output logic          ear_load,
  output logic [AW-1:0] ear_val
);

  always_comb begin
    take      = 1'b0;
    take_sync = 1'b0;
    sel_code  = '0;
    sel_epc   = core_pc;
    sel_dslot = core_dslot;
    ear_load  = 1'b0;
    ear_val   = pend_addr;
    if (pend_valid) begin
      take      = 1'b1;
      take_sync = 1'b1;
      sel_code  = pend_code;
      sel_dslot = pend_dslot;
      sel_epc   = (pend_code == CW'(EXC_SYSCALL)) ? pend_pc + AW'(INSN_BYTES) : pend_pc;
      ear_load  = 1'b1;
      ear_val   = (pend_code == CW'(EXC_ILLEGAL)) ? pend_pc : pend_addr;
    end else if (irq_tick && tick_en) begin
      take     = 1'b1;
      sel_code = CW'(EXC_TICK);
    end else if (irq_ext && ext_en) begin
      take     = 1'b1;
      sel_code = CW'(EXC_EXTINT);
    end
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector import exc_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter logic [AW-1:0] HIGH_BASE = 32'hF000_0000
) (
  input  logic [CW-1:0] code,
  input  logic          base_en,
  input  logic [AW-1:0] base,
  input  logic          high_en,
  output logic [AW-1:0] vec
);

  logic [AW-1:0] raw, base_part, high_part;

  assign raw = AW'(code) << VEC_SHIFT;

  generate
    if (HIGH_BASE == '0) begin : g_no_high
      assign high_part = '0;
    end else begin : g_high
      assign high_part = high_en ? HIGH_BASE : '0;
    end
  endgenerate

  assign base_part = base_en ? base : '0;
  assign vec       = raw | base_part | high_part;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl import exc_pkg::*; #(
  parameter int AW = 32,
  parameter int SRW = 16,
  parameter int NUM_CAUSES = 12,
  parameter logic [AW-1:0] HIGH_BASE = 32'hF000_0000,
  localparam int CW = $clog2(NUM_CAUSES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exc_req_valid,
  input  logic [CW-1:0]  exc_req_code,
  input  logic [AW-1:0]  core_pc,
  input  logic           core_in_dslot,
  input  logic [AW-1:0]  core_fault_addr,
  input  logic           irq_ext_pending,
  input  logic           irq_tick_pending,
  input  logic           cfg_vbar_present,
  input  logic [AW-1:0]  vbar_base,
  input  logic           sr_wr_en,
  input  logic [SRW-1:0] sr_wr_data,
  output logic [SRW-1:0] sr_q,
  output logic [SRW-1:0] esr_q,
  output logic [AW-1:0]  epc_q,
  output logic [AW-1:0]  eear_q,
  output logic           redirect_valid,
  output logic [AW-1:0]  redirect_pc,
  output logic           bad_code_err
);

  localparam logic [SRW-1:0] SR_RESET = SRW'(1) << SR_SUP;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic          pend_valid, pend_dslot;
  logic [CW-1:0] pend_code;
  logic [AW-1:0] pend_pc, pend_addr;
  logic          take, take_sync, sel_dslot, ear_load;
  logic [CW-1:0] sel_code;
  logic [AW-1:0] sel_epc, ear_val, vec;
  logic [SRW-1:0] sr_d;
  logic          sr_en;

  exc_capture #(.AW(AW), .NUM_CAUSES(NUM_CAUSES), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(exc_req_valid), .req_code(exc_req_code), .req_pc(core_pc),
    .req_dslot(core_in_dslot), .req_addr(core_fault_addr), .consume(take_sync),
    .pend_valid(pend_valid), .pend_code(pend_code), .pend_pc(pend_pc),
    .pend_dslot(pend_dslot), .pend_addr(pend_addr), .code_err(bad_code_err)
  );

  exc_arbiter #(.AW(AW), .CW(CW)) u_arb (
    .pend_valid(pend_valid), .pend_code(pend_code), .pend_pc(pend_pc),
    .pend_dslot(pend_dslot), .pend_addr(pend_addr),
    .irq_ext(irq_ext_pending), .irq_tick(irq_tick_pending),
    .ext_en(sr_q[SR_IEN]), .tick_en(sr_q[SR_TEN]),
    .core_pc(core_pc), .core_dslot(core_in_dslot),
    .take(take), .take_sync(take_sync), .sel_code(sel_code), .sel_epc(sel_epc),
    .sel_dslot(sel_dslot), .ear_load(ear_load), .ear_val(ear_val)
  );

  exc_vector #(.AW(AW), .CW(CW), .HIGH_BASE(HIGH_BASE)) u_vec (
    .code(sel_code), .base_en(cfg_vbar_present), .base(vbar_base),
    .high_en(sr_q[SR_HIV]), .vec(vec)
  );

  // next status: entry overrides a core write in the same cycle
  always_comb begin
    sr_d  = sr_q;
    sr_en = take | sr_wr_en;
    if (take) begin
      sr_d[SR_SUP]  = 1'b1;
      sr_d[SR_TEN]  = 1'b0;
      sr_d[SR_IEN]  = 1'b0;
      sr_d[SR_DMMU] = 1'b0;
      sr_d[SR_IMMU] = 1'b0;
      sr_d[SR_DSX]  = sel_dslot;
    end else if (sr_wr_en) begin
      sr_d = sr_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  sr_q <= SR_RESET;
    else if (sr_en)  sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      esr_q       <= '0;
      epc_q       <= '0;
      redirect_pc <= '0;
    end else if (take) begin
      esr_q       <= sr_q;
      epc_q       <= sel_epc;
      redirect_pc <= vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)           eear_q <= '0;
    else if (take && ear_load) eear_q <= ear_val;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) redirect_valid <= 1'b0;
    else            redirect_valid <= take;
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 32,
  parameter int SRW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [SRW-1:0] sr_q,
  input logic [SRW-1:0] esr_q,
  input logic           redirect_valid,
  input logic [AW-1:0]  redirect_pc,
  input logic           bad_code_err,
  input logic           cfg_vbar_present,
  input logic           sr_wr_en
);

  // R5
  safe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (sr_q[0] && !sr_q[1] && !sr_q[2] && !sr_q[3] && !sr_q[4]));

  // R4
  esr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (esr_q == $past(sr_q)));

  // R3
  plain_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !$past(cfg_vbar_present) && !$past(sr_q[5]))
      |-> (redirect_pc[AW-1:12] == '0 && redirect_pc[7:0] == '0 && redirect_pc[11:8] != '0));

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code_err |=> bad_code_err);

  // R11
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_valid && !$past(sr_wr_en)) |-> $stable(sr_q));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .SRW(SRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_q(sr_q), .esr_q(esr_q),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .bad_code_err(bad_code_err), .cfg_vbar_present(cfg_vbar_present),
  .sr_wr_en(sr_wr_en)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        exc_req_valid;
  logic [3:0]  exc_req_code;
  logic [31:0] core_pc, core_fault_addr, vbar_base;
  logic        core_in_dslot, irq_ext_pending, irq_tick_pending, cfg_vbar_present;
  logic        sr_wr_en;
  logic [15:0] sr_wr_data;
  logic [15:0] sr_q, esr_q;
  logic [31:0] epc_q, eear_q, redirect_pc;
  logic        redirect_valid, bad_code_err;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .exc_req_valid(exc_req_valid), .exc_req_code(exc_req_code),
    .core_pc(core_pc), .core_in_dslot(core_in_dslot), .core_fault_addr(core_fault_addr),
    .irq_ext_pending(irq_ext_pending), .irq_tick_pending(irq_tick_pending),
    .cfg_vbar_present(cfg_vbar_present), .vbar_base(vbar_base),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_q(sr_q), .esr_q(esr_q), .epc_q(epc_q), .eear_q(eear_q),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .bad_code_err(bad_code_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0, chk_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_sr, m_esr;
  logic [31:0] m_epc, m_ear, m_rpc;
  bit          m_rv, m_err;
  bit          m_pv, m_pds;
  int          m_pcode;
  logic [31:0] m_ppc, m_paddr;
  bit          t_take, t_ds, t_eld;
  int          t_code;
  logic [31:0] t_epc, t_ear;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr = 16'h0001; m_esr = 0; m_epc = 0; m_ear = 0; m_rpc = 0;
      m_rv = 0; m_err = 0; m_pv = 0; m_pds = 0; m_pcode = 0; m_ppc = 0; m_paddr = 0;
    end else begin
      t_take = 0; t_eld = 0; t_code = 0; t_ds = core_in_dslot; t_epc = core_pc; t_ear = 0;
      if (m_pv) begin
        t_take = 1; t_code = m_pcode; t_ds = m_pds; t_eld = 1;
        t_epc = (m_pcode == 12) ? m_ppc + 4 : m_ppc;
        t_ear = (m_pcode == 7) ? m_ppc : m_paddr;
      end else if (irq_tick_pending && m_sr[1]) begin
        t_take = 1; t_code = 5;
      end else if (irq_ext_pending && m_sr[2]) begin
        t_take = 1; t_code = 8;
      end
      if (t_take) begin
        m_rpc = (32'(t_code) * 256) | (cfg_vbar_present ? vbar_base : 32'h0)
              | (m_sr[5] ? 32'hF000_0000 : 32'h0);
        m_esr = m_sr;
        m_sr  = (m_sr & ~16'h005E) | 16'h0001 | (t_ds ? 16'h0040 : 16'h0000);
        m_epc = t_epc;
        if (t_eld) m_ear = t_ear;
      end else if (sr_wr_en) begin
        m_sr = sr_wr_data;
      end
      m_rv = t_take;
      if (t_take && m_pv) m_pv = 0;
      if (exc_req_valid) begin
        if (exc_req_code >= 1 && exc_req_code <= 12) begin
          m_pv = 1; m_pcode = int'(exc_req_code); m_ppc = core_pc;
          m_pds = core_in_dslot; m_paddr = core_fault_addr;
        end else m_err = 1;
      end
    end
  end

  // per-cycle comparison and redirect monitor
  int          n_redir = 0;
  logic [31:0] last_rpc = 0;
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      chk(sr_q == m_sr, "R5", "sr", 32'(sr_q), 32'(m_sr));
      chk(esr_q == m_esr, "R4", "esr", 32'(esr_q), 32'(m_esr));
      chk(epc_q == m_epc, "R6", "epc", epc_q, m_epc);
      chk(eear_q == m_ear, "R7", "eear", eear_q, m_ear);
      chk(redirect_valid == m_rv, "R2", "redirect_valid", 32'(redirect_valid), 32'(m_rv));
      chk(bad_code_err == m_err, "R10", "bad_code_err", 32'(bad_code_err), 32'(m_err));
      if (m_rv) chk(redirect_pc == m_rpc, "R3", "redirect_pc", redirect_pc, m_rpc);
    end
    if (rst_n && redirect_valid) begin
      n_redir++;
      last_rpc = redirect_pc;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_sr(input logic [15:0] v);
    @(negedge clk); sr_wr_en = 1; sr_wr_data = v;
    @(negedge clk); sr_wr_en = 0;
  endtask

  task automatic send_sync(input logic [3:0] c, input logic [31:0] pc,
                           input bit ds, input logic [31:0] fa);
    @(negedge clk);
    exc_req_valid = 1; exc_req_code = c; core_pc = pc; core_in_dslot = ds; core_fault_addr = fa;
    @(negedge clk);
    exc_req_valid = 0; core_in_dslot = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int base_n;
    logic [15:0] sr_before;
    logic [31:0] exp_pc;
    rst_n = 0; exc_req_valid = 0; exc_req_code = 0; core_pc = 32'h100; core_in_dslot = 0;
    core_fault_addr = 0; irq_ext_pending = 0; irq_tick_pending = 0; cfg_vbar_present = 0;
    vbar_base = 32'h00A0_0000; sr_wr_en = 0; sr_wr_data = 0;
    wait_n(3);
    rst_n = 1;
    wait_n(4);
    // R1 reset state
    chk(sr_q == 16'h0001, "R1", "sr after reset", 32'(sr_q), 32'h1);
    chk(esr_q == 0 && epc_q == 0 && eear_q == 0, "R1", "shadow regs", epc_q | eear_q, 0);
    chk(!redirect_valid && !bad_code_err, "R1", "redirect/err", 32'(redirect_valid), 0);
    chk_on = 1;

    // every supported synchronous code
    for (int c = 1; c <= 12; c++) begin
      bit ds = c[0];
      cfg_vbar_present = c[1];
      wr_sr(c > 6 ? 16'h0021 : 16'h0019);
      sr_before = sr_q;
      base_n = n_redir;
      send_sync(4'(c), 32'h4000 + 32'(c) * 16, ds, 32'hBEEF_0000 + 32'(c));
      wait_n(2);
      chk(n_redir == base_n + 1, "R2", "one pulse per request", 32'(n_redir - base_n), 1);
      exp_pc = (32'(c) << 8) | (c[1] ? 32'h00A0_0000 : 0) | (c > 6 ? 32'hF000_0000 : 0);
      chk(last_rpc == exp_pc, "R3", "vector", last_rpc, exp_pc);
      chk(esr_q == sr_before, "R4", "saved status", 32'(esr_q), 32'(sr_before));
      chk(sr_q[6] == ds && sr_q[0] && sr_q[4:1] == 0, "R5", "entry status", 32'(sr_q), 32'(ds));
      exp_pc = 32'h4000 + 32'(c) * 16 + (c == 12 ? 4 : 0);
      chk(epc_q == exp_pc, "R6", "return pc", epc_q, exp_pc);
      exp_pc = (c == 7) ? 32'h4000 + 32'(c) * 16 : 32'hBEEF_0000 + 32'(c);
      chk(eear_q == exp_pc, "R7", "effective address", eear_q, exp_pc);
    end
    cfg_vbar_present = 0;

    // unsupported codes
    base_n = n_redir;
    send_sync(4'd0, 32'h900, 0, 0);
    wait_n(2);
    chk(n_redir == base_n && bad_code_err, "R10", "code 0 dropped", 32'(n_redir - base_n), 0);
    send_sync(4'd13, 32'h904, 0, 0);
    send_sync(4'd15, 32'h908, 0, 0);
    wait_n(3);
    chk(n_redir == base_n && bad_code_err, "R10", "codes 13/15 dropped", 32'(n_redir - base_n), 0);

    // interrupt gating
    wr_sr(16'h0001);
    base_n = n_redir;
    core_pc = 32'h7000;
    irq_ext_pending = 1;
    wait_n(3);
    chk(n_redir == base_n, "R8", "ext masked", 32'(n_redir - base_n), 0);
    wr_sr(16'h0005);
    wait_n(2);
    irq_ext_pending = 0;
    chk(n_redir == base_n + 1 && last_rpc[11:8] == 8, "R8", "ext taken", last_rpc, 32'h800);
    chk(eear_q == 32'hBEEF_000C, "R7", "interrupt keeps eear", eear_q, 32'hBEEF_000C);
    wr_sr(16'h0007);
    base_n = n_redir;
    irq_ext_pending = 1; irq_tick_pending = 1;
    @(negedge clk);
    irq_ext_pending = 0; irq_tick_pending = 0;
    wait_n(2);
    chk(n_redir == base_n + 1 && last_rpc[11:8] == 5, "R8", "tick over ext", last_rpc, 32'h500);

    // sync over tick
    wr_sr(16'h0007);
    base_n = n_redir;
    @(negedge clk);
    exc_req_valid = 1; exc_req_code = 4'd6; core_pc = 32'h5000; core_fault_addr = 32'h5003;
    @(negedge clk);
    exc_req_valid = 0; irq_tick_pending = 1;
    @(negedge clk);
    irq_tick_pending = 0;
    wait_n(2);
    chk(n_redir == base_n + 1 && last_rpc[11:8] == 6, "R9", "sync wins", last_rpc, 32'h600);

    // status write port
    wr_sr(16'h0026);
    wait_n(1);
    chk(sr_q == 16'h0026, "R11", "plain write", 32'(sr_q), 32'h26);
    @(negedge clk);
    exc_req_valid = 1; exc_req_code = 4'd2; core_pc = 32'h6000;
    @(negedge clk);
    exc_req_valid = 0; sr_wr_en = 1; sr_wr_data = 16'h0006;
    @(negedge clk);
    sr_wr_en = 0;
    chk(sr_q == 16'h0021, "R11", "write lost to entry", 32'(sr_q), 32'h21);
    wait_n(3);
    finish_run();
  end

endmodule